// File: doc/BRIEF.md
# Fixed-Point Multiply Execution Unit

This block is the multiply stage of a 16-bit fixed-point signal processor. It decodes the multiply opcodes in a 16-bit instruction word and takes its operands from the register file. The operands are the low and high 16-bit halves of two secondary accumulators (ax0, ax1) and the middle 16-bit word of two main accumulators (ac0, ac1). It forms a signed 16x16 product, doubled unless the status mode input says otherwise, and keeps it in a 40-bit product register. That register can be loaded, accumulated into or subtracted from.

Several opcodes also write a main accumulator in the same instruction. The value written is derived from the product register as it stood before this instruction's multiply. Each executed instruction also updates zero, sign and overflow flags. All results appear on the clock edge after a valid opcode. The register file outside this block applies the accumulator write strobe.

Top module: `mpy_exec_unit`

## Requirements
- R1: After reset the product register is 0, the accumulator write strobe is 0 and all three flags are 0.
- R2: Operands are signed two's-complement 16-bit values. The 32-bit product is sign-extended to 40 bits. It is doubled (shifted left one bit) when `mul_unscaled` is 0 and used as is when it is 1.
- R3: Cross family (opcode bits 15:13 = 101): the first operand is ax0 and the second is ax1. Bit 12 picks the ax0 half and bit 11 picks the ax1 half, where 0 is the low half and 1 is the high half. The product register is loaded with the new product.
- R4: Opcode bits 15:12 = 1001 multiply axS.lo by axS.hi, with S given by bit 11. Opcode bits 15:13 = 110 multiply acS.mid by axT.hi, with S given by bit 12 and T by bit 11. Both load the product register.
- R5: In the three families of R3 and R4, bits 10:9 select the accumulator action and bit 8 selects accumulator 0 or 1. The actions are: 00 no write; 01 write the old product with bits 15:0 zeroed; 10 write the selected accumulator input plus the old product (40-bit wrap); 11 write the old product. The write shows as `acc_we`=1 with `acc_sel` and `acc_wdata` in the cycle after the opcode, and `acc_we` is 0 after any other cycle.
- R6: The following opcodes accumulate, with new = old + product or new = old - product, wrapping at 40 bits.
  - 1110 00st adds and 1110 01st subtracts, using ax0 half s (bit 9) times ax1 half t (bit 8).
  - 1110 10st adds and 1110 11st subtracts, using acS.mid (S = bit 9) times axT.hi (T = bit 8).
  - 1111 001s adds and 1111 011s subtracts, using axS.lo times axS.hi (S = bit 8).
- R7: Opcode high byte 0x84 clears the product register. It loads the four 16-bit product parts 0x0000, 0xFFF0, 0x00FF and 0x0010. These combine as part0 + (part1 + part3)<<16 + part2<<32, truncated to 40 bits, which gives 0.
- R8: On every executed opcode, `flag_zero` and `flag_sign` follow the new product register value (equal to 0, bit 39). `flag_ovf` is 1 exactly when an R6 add or subtract overflows the signed 40-bit range.
- R9: With `op_valid` low, or an opcode not listed in R3 to R7, the product register and flags hold and `acc_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 16 | Instruction word |
| mul_unscaled | input | 1 | Status mode bit: 1 disables product doubling |
| ax0_lo | input | 16 | ax0 low half |
| ax0_hi | input | 16 | ax0 high half |
| ax1_lo | input | 16 | ax1 low half |
| ax1_hi | input | 16 | ax1 high half |
| ac0_mid | input | 16 | ac0 middle word |
| ac1_mid | input | 16 | ac1 middle word |
| ac0_in | input | 40 | Full ac0 value, for the add action |
| ac1_in | input | 40 | Full ac1 value, for the add action |
| prod_q | output | 40 | Product register |
| acc_we | output | 1 | Accumulator write strobe |
| acc_sel | output | 1 | Accumulator written (0 or 1) |
| acc_wdata | output | 40 | Accumulator write value |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Result is negative |
| flag_ovf | output | 1 | Accumulate overflowed 40 bits |

## Verification
The bench runs long chains of move and accumulate opcodes back to back. A unit that moved the new product instead of the old one would write an accumulator value one instruction ahead of the model. Operands of 0x8000 times 0x8000 with doubling yield +2^31; a product kept at 32 bits would turn negative. Hundreds of such accumulations push the product register past both 40-bit limits, so a missing or wrongly signed overflow flag shows up at the exact crossing cycle. Directed opcodes toggle each half-select, accumulator-select and clear bit in turn, and unlisted opcodes are mixed in, so a swapped select or a clear that leaves nonzero parts shows at once.

// File: rtl/mpy_pkg.sv
package mpy_pkg;
  typedef enum logic [1:0] {
    SRC_AX_SELF  = 2'd0,
    SRC_AX_CROSS = 2'd1,
    SRC_AC_MID   = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    PO_LOAD  = 2'd0,
    PO_ADD   = 2'd1,
    PO_SUB   = 2'd2,
    PO_CLEAR = 2'd3
  } pop_e;

  // encoding equals opcode bits 10:9
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_ZLO  = 2'b01,
    ACT_ADD  = 2'b10,
    ACT_MOVE = 2'b11
  } act_e;

  typedef struct packed {
    logic hit;
    src_e src;
    logic sel_a;
    logic sel_b;
    pop_e pop;
    act_e act;
    logic rsel;
  } ctrl_t;
endpackage

// File: rtl/mpy_decode.sv
module mpy_decode import mpy_pkg::*; #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0] opcode,
  output ctrl_t          ctrl
);
  logic [7:0] hb;
  logic       unused_low;
  assign hb         = opcode[OPW-1 -: 8];
  assign unused_low = ^opcode[OPW-9:0];

  always_comb begin
    ctrl = '0;
    casez (hb)
      8'b1000_0100: begin
        ctrl.hit = 1'b1;
        ctrl.pop = PO_CLEAR;
      end
      8'b1001_????: begin
        ctrl.hit   = 1'b1;
        ctrl.src   = SRC_AX_SELF;
        ctrl.sel_a = hb[3];
        ctrl.act   = act_e'(hb[2:1]);
        ctrl.rsel  = hb[0];
      end
      8'b101?_????, 8'b110?_????: begin
        ctrl.hit   = 1'b1;
        ctrl.src   = hb[6] ? SRC_AC_MID : SRC_AX_CROSS;
        ctrl.sel_a = hb[4];
        ctrl.sel_b = hb[3];
        ctrl.act   = act_e'(hb[2:1]);
        ctrl.rsel  = hb[0];
      end
      8'b1110_????: begin
        ctrl.hit   = 1'b1;
        ctrl.src   = hb[3] ? SRC_AC_MID : SRC_AX_CROSS;
        ctrl.pop   = hb[2] ? PO_SUB : PO_ADD;
        ctrl.sel_a = hb[1];
        ctrl.sel_b = hb[0];
      end
      8'b1111_0?1?: begin
        ctrl.hit   = 1'b1;
        ctrl.src   = SRC_AX_SELF;
        ctrl.pop   = hb[2] ? PO_SUB : PO_ADD;
        ctrl.sel_a = hb[0];
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mpy_opsel.sv
module mpy_opsel import mpy_pkg::*; #(
  parameter int DW = 16
) (
  input  src_e                src,
  input  logic                sel_a,
  input  logic                sel_b,
  input  logic [1:0][DW-1:0]  ax_lo,
  input  logic [1:0][DW-1:0]  ax_hi,
  input  logic [1:0][DW-1:0]  ac_mid,
  output logic [DW-1:0]       op_a,
  output logic [DW-1:0]       op_b
);
  always_comb begin
    case (src)
      SRC_AX_SELF: begin
        op_a = ax_lo[sel_a];
        op_b = ax_hi[sel_a];
      end
      SRC_AX_CROSS: begin
        op_a = sel_a ? ax_hi[0] : ax_lo[0];
        op_b = sel_b ? ax_hi[1] : ax_lo[1];
      end
      SRC_AC_MID: begin
        op_a = ac_mid[sel_a];
        op_b = ax_hi[sel_b];
      end
      default: begin
        op_a = '0;
        op_b = '0;
      end
    endcase
  end
endmodule

// File: rtl/mpy_arith.sv
module mpy_arith import mpy_pkg::*; #(
  parameter int DW = 16,
  parameter int PW = 40
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          unscaled,
  input  pop_e          pop,
  input  act_e          act,
  input  logic [PW-1:0] prod_old,
  input  logic [PW-1:0] acc_src,
  output logic [PW-1:0] prod_new,
  output logic          ovf,
  output logic [PW-1:0] acc_val
);
  localparam int RW = 2 * DW;
  localparam logic [63:0] PART0 = 64'h0000;
  localparam logic [63:0] PART1 = 64'hFFF0;
  localparam logic [63:0] PART2 = 64'h00FF;
  localparam logic [63:0] PART3 = 64'h0010;

  function automatic logic [PW-1:0] clear_image();
    logic [63:0] t;
    t = PART0 + ((PART1 + PART3) << DW) + (PART2 << RW);
    return t[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] scaled_product(logic [DW-1:0] x, logic [DW-1:0] y,
                                                   logic no_dbl);
    logic signed [RW-1:0] raw;
    logic [PW-1:0]        ext;
    raw = $signed(x) * $signed(y);
    ext = {{(PW-RW){raw[RW-1]}}, raw};
    return no_dbl ? ext : {ext[PW-2:0], 1'b0};
  endfunction

  localparam logic [PW-1:0] CLR_IMAGE = clear_image();

  logic [PW-1:0] mul_ext;
  logic [PW-1:0] sum;
  logic [PW-1:0] dif;
  logic          sum_ovf;
  logic          dif_ovf;

  assign mul_ext = scaled_product(op_a, op_b, unscaled);
  assign sum     = prod_old + mul_ext;
  assign dif     = prod_old - mul_ext;
  assign sum_ovf = (prod_old[PW-1] == mul_ext[PW-1]) && (sum[PW-1] != prod_old[PW-1]);
  assign dif_ovf = (prod_old[PW-1] != mul_ext[PW-1]) && (dif[PW-1] != prod_old[PW-1]);

  always_comb begin
    case (pop)
      PO_ADD:   begin prod_new = sum;       ovf = sum_ovf; end
      PO_SUB:   begin prod_new = dif;       ovf = dif_ovf; end
      PO_CLEAR: begin prod_new = CLR_IMAGE; ovf = 1'b0;    end
      default:  begin prod_new = mul_ext;   ovf = 1'b0;    end
    endcase
    case (act)
      ACT_ZLO: acc_val = {prod_old[PW-1:DW], {DW{1'b0}}};
      ACT_ADD: acc_val = acc_src + prod_old;
      default: acc_val = prod_old;
    endcase
  end
endmodule

// File: rtl/mpy_exec_unit.sv
module mpy_exec_unit import mpy_pkg::*; #(
  parameter int DW = 16,
  parameter int PW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [15:0]   opcode,
  input  logic          mul_unscaled,
  input  logic [DW-1:0] ax0_lo,
  input  logic [DW-1:0] ax0_hi,
  input  logic [DW-1:0] ax1_lo,
  input  logic [DW-1:0] ax1_hi,
  input  logic [DW-1:0] ac0_mid,
  input  logic [DW-1:0] ac1_mid,
  input  logic [PW-1:0] ac0_in,
  input  logic [PW-1:0] ac1_in,
  output logic [PW-1:0] prod_q,
  output logic          acc_we,
  output logic          acc_sel,
  output logic [PW-1:0] acc_wdata,
  output logic          flag_zero,
  output logic          flag_sign,
  output logic          flag_ovf
);
  ctrl_t         ctrl;
  logic [DW-1:0] op_a;
  logic [DW-1:0] op_b;
  logic [PW-1:0] prod_d;
  logic [PW-1:0] acc_d;
  logic          ovf_d;
  logic          op_fire;
  logic          acc_fire;

  mpy_decode #(.OPW(16)) u_dec (.opcode(opcode), .ctrl(ctrl));

  mpy_opsel #(.DW(DW)) u_sel (
    .src(ctrl.src), .sel_a(ctrl.sel_a), .sel_b(ctrl.sel_b),
    .ax_lo({ax1_lo, ax0_lo}), .ax_hi({ax1_hi, ax0_hi}), .ac_mid({ac1_mid, ac0_mid}),
    .op_a(op_a), .op_b(op_b)
  );

  mpy_arith #(.DW(DW), .PW(PW)) u_ar (
    .op_a(op_a), .op_b(op_b), .unscaled(mul_unscaled), .pop(ctrl.pop), .act(ctrl.act),
    .prod_old(prod_q), .acc_src(ctrl.rsel ? ac1_in : ac0_in),
    .prod_new(prod_d), .ovf(ovf_d), .acc_val(acc_d)
  );

  assign op_fire  = op_valid && ctrl.hit;
  assign acc_fire = op_fire && (ctrl.act != ACT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q    <= '0;
      acc_we    <= 1'b0;
      acc_sel   <= 1'b0;
      acc_wdata <= '0;
      flag_zero <= 1'b0;
      flag_sign <= 1'b0;
      flag_ovf  <= 1'b0;
    end else begin
      acc_we <= acc_fire;
      if (acc_fire) begin
        acc_sel   <= ctrl.rsel;
        acc_wdata <= acc_d;
      end
      if (op_fire) begin
        prod_q    <= prod_d;
        flag_zero <= (prod_d == '0);
        flag_sign <= prod_d[PW-1];
        flag_ovf  <= ovf_d;
      end
    end
  end

  // R9
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_fire |=> $stable(prod_q) && !acc_we);

  // R5
  acc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && ctrl.act == ACT_MOVE) |=> (acc_wdata == $past(prod_q)));

  // R5
  acc_zlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && ctrl.act == ACT_ZLO) |=>
      (acc_wdata[DW-1:0] == '0) && (acc_wdata[PW-1:DW] == $past(prod_q[PW-1:DW])));

  // R8
  flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> (flag_zero == (prod_q == '0)) && (flag_sign == prod_q[PW-1]));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && (ctrl.pop == PO_LOAD || ctrl.pop == PO_CLEAR)) |=> !flag_ovf);

  // R2
  dbl_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && ctrl.pop == PO_LOAD && !mul_unscaled) |=> !prod_q[0]);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && ctrl.pop == PO_CLEAR) |=> (prod_q == '0) && flag_zero);
endmodule

// File: tb/mpy_exec_unit_tb_top.sv
module mpy_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic        mul_unscaled = 1'b0;
  logic [15:0] ax0_lo = '0, ax0_hi = '0, ax1_lo = '0, ax1_hi = '0, ac0_mid = '0, ac1_mid = '0;
  logic [39:0] ac0_in = '0, ac1_in = '0;
  logic [39:0] prod_q, acc_wdata;
  logic        acc_we, acc_sel, flag_zero, flag_sign, flag_ovf;

  int checks = 0;
  int errors = 0;

  // staged stimulus
  logic [15:0] s_ax0l, s_ax0h, s_ax1l, s_ax1h, s_ac0m, s_ac1m;
  logic [39:0] s_ac0, s_ac1;

  // reference state
  longint e_prod;
  longint e_wdata;
  logic   e_we, e_sel, e_z, e_s, e_o;
  string  tag;

  localparam longint PMAX = 64'sh7F_FFFF_FFFF;
  localparam longint PMIN = -64'sh80_0000_0000;

  always #5 clk = ~clk;

  mpy_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .mul_unscaled(mul_unscaled),
    .ax0_lo(ax0_lo), .ax0_hi(ax0_hi), .ax1_lo(ax1_lo), .ax1_hi(ax1_hi),
    .ac0_mid(ac0_mid), .ac1_mid(ac1_mid), .ac0_in(ac0_in), .ac1_in(ac1_in),
    .prod_q(prod_q), .acc_we(acc_we), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_ovf(flag_ovf)
  );

  function automatic longint sx16(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint wrap40(longint v);
    logic [39:0] t;
    t = v[39:0];
    return longint'($signed(t));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag, {24'd0, prod_q}, {24'd0, e_prod[39:0]});
    chk("R8", {61'd0, flag_zero, flag_sign, flag_ovf}, {61'd0, e_z, e_s, e_o});
    chk(e_we ? "R5" : "R9", {63'd0, acc_we}, {63'd0, e_we});
    if (e_we) chk("R5", {23'd0, acc_sel, acc_wdata}, {23'd0, e_sel, e_wdata[39:0]});
  endtask

  task automatic model(logic rst, logic v, logic [15:0] op, logic u);
    logic [7:0] h;
    logic [15:0] a, b;
    logic hit, acts;
    int po; // 0 load 1 add 2 sub 3 clear
    longint nw, old, t, accv;
    h = op[15:8]; hit = 1'b1; acts = 1'b0; po = 0; a = '0; b = '0;
    if (!rst) begin
      e_prod = 0; e_we = 0; e_sel = 0; e_wdata = 0; e_z = 0; e_s = 0; e_o = 0; tag = "R1";
      return;
    end
    if (h == 8'h84) begin po = 3; tag = "R7"; end
    else if (h[7:4] == 4'b1001) begin
      a = op[11] ? s_ax1l : s_ax0l; b = op[11] ? s_ax1h : s_ax0h; acts = 1; tag = "R4";
    end else if (h[7:5] == 3'b101) begin
      a = op[12] ? s_ax0h : s_ax0l; b = op[11] ? s_ax1h : s_ax1l; acts = 1; tag = "R3";
    end else if (h[7:5] == 3'b110) begin
      a = op[12] ? s_ac1m : s_ac0m; b = op[11] ? s_ax1h : s_ax0h; acts = 1; tag = "R4";
    end else if (h[7:4] == 4'hE) begin
      po = op[10] ? 2 : 1; tag = "R6";
      if (!op[11]) begin a = op[9] ? s_ax0h : s_ax0l; b = op[8] ? s_ax1h : s_ax1l; end
      else begin a = op[9] ? s_ac1m : s_ac0m; b = op[8] ? s_ax1h : s_ax0h; end
    end else if (h[7:1] == 7'b1111001 || h[7:1] == 7'b1111011) begin
      po = h[2] ? 2 : 1; tag = "R6";
      a = op[8] ? s_ax1l : s_ax0l; b = op[8] ? s_ax1h : s_ax0h;
    end else hit = 1'b0;
    if (!v || !hit) begin e_we = 0; tag = "R9"; return; end
    if (po == 0 && u) tag = "R2";
    nw = sx16(a) * sx16(b);
    if (!u) nw = nw * 2;
    old = e_prod;
    e_o = 0;
    case (po)
      0: e_prod = nw;
      1: begin t = old + nw; e_o = (t > PMAX) || (t < PMIN); e_prod = wrap40(t); end
      2: begin t = old - nw; e_o = (t > PMAX) || (t < PMIN); e_prod = wrap40(t); end
      default: e_prod = wrap40(64'h00FF * 64'h1_0000_0000 + (64'hFFF0 + 64'h0010) * 64'h1_0000);
    endcase
    e_z = (e_prod == 0); e_s = (e_prod < 0);
    e_we = acts && (op[10:9] != 2'b00);
    if (e_we) begin
      e_sel = op[8];
      accv = op[8] ? longint'($signed(s_ac1)) : longint'($signed(s_ac0));
      case (op[10:9])
        2'b01: e_wdata = old & 64'hFFFF_FFFF_FFFF_0000;
        2'b10: e_wdata = wrap40(accv + old);
        default: e_wdata = old;
      endcase
    end
  endtask

  task automatic step(logic rst, logic v, logic [15:0] op, logic u);
    @(negedge clk);
    compare();
    rst_n = rst; op_valid = v; opcode = op; mul_unscaled = u;
    ax0_lo = s_ax0l; ax0_hi = s_ax0h; ax1_lo = s_ax1l; ax1_hi = s_ax1h;
    ac0_mid = s_ac0m; ac1_mid = s_ac1m; ac0_in = s_ac0; ac1_in = s_ac1;
    model(rst, v, op, u);
  endtask

  function automatic logic [15:0] rop16();
    logic [15:0] r;
    r = 16'($urandom);
    case ($urandom % 8)
      0: r = 16'h8000;
      1: r = 16'h7FFF;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] rhi();
    logic [7:0] r;
    r = 8'($urandom);
    case ($urandom % 9)
      0: r = 8'h84;
      1: r = {4'b1001, r[3:0]};
      2: r = {3'b101, r[4:0]};
      3: r = {3'b110, r[4:0]};
      4, 5: r = {4'b1110, r[3:0]};
      6: r = {5'b11110, r[2], 1'b1, r[0]};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    s_ax0l = 16'h0003; s_ax0h = 16'hFFFE; s_ax1l = 16'h0005; s_ax1h = 16'h7FFF;
    s_ac0m = 16'h1234; s_ac1m = 16'h8000;
    s_ac0 = 40'h00_1111_2222; s_ac1 = 40'hFF_8000_0001;
    tag = "R1"; e_prod = 0; e_we = 0; e_sel = 0; e_wdata = 0; e_z = 0; e_s = 0; e_o = 0;
    // R1: reset state
    repeat (3) step(1'b0, 1'b0, 16'h0000, 1'b0);
    // R7 clear, R3 cross selects, R2 scaling
    step(1, 1, 16'h8400, 0);
    step(1, 1, 16'hA000, 0);
    step(1, 1, 16'hB800, 0);
    step(1, 1, 16'hA800, 0);
    step(1, 1, 16'hB000, 1);
    // R5 actions on both accumulators
    step(1, 1, 16'hA200, 0);
    step(1, 1, 16'hA500, 0);
    step(1, 1, 16'hA600, 0);
    step(1, 1, 16'hA700, 1);
    step(1, 1, 16'hA400, 0);
    // R4 families
    step(1, 1, 16'h9000, 0);
    step(1, 1, 16'h9800, 1);
    step(1, 1, 16'h9600, 0);
    step(1, 1, 16'hC000, 0);
    step(1, 1, 16'hD800, 0);
    step(1, 1, 16'hCA00, 0);
    step(1, 1, 16'hDD00, 0);
    // R6 accumulate forms
    step(1, 1, 16'hE000, 0);
    step(1, 1, 16'hE300, 0);
    step(1, 1, 16'hE400, 1);
    step(1, 1, 16'hE700, 0);
    step(1, 1, 16'hE900, 0);
    step(1, 1, 16'hEE00, 0);
    step(1, 1, 16'hF200, 0);
    step(1, 1, 16'hF300, 0);
    step(1, 1, 16'hF600, 0);
    step(1, 1, 16'hF700, 1);
    // R9 ignored opcodes
    step(1, 1, 16'h8000, 0);
    step(1, 1, 16'hF800, 0);
    step(1, 0, 16'hE000, 0);
    step(1, 1, 16'h8500, 0);
    // R8 overflow at both 40-bit limits
    s_ax0l = 16'h8000; s_ax0h = 16'h8000;
    step(1, 1, 16'h8400, 0);
    for (int i = 0; i < 260; i++) step(1, 1, 16'hF200, 0);
    step(1, 1, 16'h8400, 0);
    for (int i = 0; i < 260; i++) step(1, 1, 16'hF600, 0);
    step(1, 1, 16'hA600, 0);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      s_ax0l = rop16(); s_ax0h = rop16(); s_ax1l = rop16(); s_ax1h = rop16();
      s_ac0m = rop16(); s_ac1m = rop16();
      s_ac0 = {8'($urandom), 32'($urandom)}; s_ac1 = {8'($urandom), 32'($urandom)};
      step(1, ($urandom % 5) != 0, {rhi(), 8'($urandom)}, 1'($urandom));
    end
    step(1, 0, 16'h0000, 0);
    step(1, 0, 16'h0000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule